// File: doc/BRIEF.md
# Block-Transfer NVRAM Slave

This block is a 1024-byte memory that a host reaches over a byte-level SMBus-style slave interface. A bus front end outside the block turns the bit stream into single-cycle events: a start condition, a written byte, or a request for a read byte. Each event carries the 7-bit device address it was sent to. The block answers every event addressed to it one cycle later, with ACK or NAK and, for reads, a data byte.

The slave occupies four consecutive device addresses. A mapping byte sets their base and holds the enable bit. The two low bits of the device address become the upper two bits of the 10-bit memory pointer. A write transfer sends the low pointer byte first, then a 6-bit block length, then that many data bytes. The byte that uses up the length is stored but answered with NAK, and every write after it is refused until the next start. A read transfer returns a configured length byte first and then memory bytes from the pointer onward. A dirty flag tells the owner that the contents changed since it last acknowledged them.

Top module: `smb_block_nvram`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_ack`, `rsp_byte` and `dirty` are all 0, and the transfer is in the pointer phase.
- R2: An event is taken only when `map_cfg[0]` is 1 and `ev_dev[6:2]` equals `map_cfg[7:3]`. Any other event gives `rsp_valid` = 0 in the following cycle and leaves all state unchanged.
- R3: A start that is taken is answered with ACK and `rsp_byte` = 0, and it returns the transfer to the pointer phase.
- R4: A byte written in the pointer phase sets the pointer to {`ev_dev[1:0]`, byte}. It is answered with ACK and moves the transfer to the length phase.
- R5: A byte written in the length phase sets the remaining count to its low 6 bits. A count of zero gives NAK and enters the terminal phase. Any other count gives ACK and enters the data phase.
- R6: A byte written in the data phase is stored at the pointer, the pointer increments by one and the count decrements by one. The answer is ACK, except for the byte that brings the count to zero: that byte is stored, answered with NAK, and the transfer enters the terminal phase.
- R7: In the terminal phase, written bytes are answered with NAK and are not stored. Only a start leaves this phase.
- R8: A read in the pointer or length phase returns `rd_len_cfg[5:0]` zero-extended to 8 bits, with ACK, and moves the transfer to the data phase.
- R9: A read in the data phase returns the memory byte at the pointer, with ACK, and then increments the pointer.
- R10: A read in the terminal phase returns 0xFF.
- R11: The pointer wraps from 1023 to 0, for both stores and reads.
- R12: `dirty` goes to 1 on the cycle after any stored byte and to 0 on the cycle after `dirty_ack`. If both happen in the same cycle, it stays 1.
- R13: The answer to an event taken at a clock edge appears on `rsp_valid`, `rsp_ack` and `rsp_byte` after that edge and lasts one cycle. Answers to writes and starts carry `rsp_byte` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start condition seen, one-cycle pulse |
| ev_wr | input | 1 | Byte written by the host, one-cycle pulse |
| ev_rd | input | 1 | Host requests a byte, one-cycle pulse |
| ev_dev | input | 7 | Device address the event is sent to |
| ev_byte | input | 8 | Written byte, valid with `ev_wr` |
| map_cfg | input | 8 | Bits 7:3 set the base of the four device addresses; bit 0 enables the slave |
| rd_len_cfg | input | 8 | Block length returned first on reads; only bits 5:0 are used |
| dirty_ack | input | 1 | Clears the dirty flag |
| rsp_valid | output | 1 | An answer is present this cycle |
| rsp_ack | output | 1 | 1 = ACK, 0 = NAK |
| rsp_byte | output | 8 | Read data; 0 for start and write answers |
| dirty | output | 1 | Memory was written since the last `dirty_ack` |

## Verification
The assertions assume that the front end raises at most one event per cycle. If several are raised together, the block ranks start above write and write above read, and the assertions judge only the event the block chose. They also assume that the mapping and length inputs stay still while a transfer is running. The stimulus always pulses a single event for exactly one cycle. It sets both configuration inputs only between transfers, and it reads memory only at locations written earlier, so that no read returns an unknown value.

// File: rtl/nvr_pkg.sv
// Package: shared phase type for the block-transfer NVRAM slave.
// Assumes: four phases cover the whole write/read protocol.
package nvr_pkg;
    typedef enum logic [1:0] {
        P_PTR  = 2'd0,
        P_LEN  = 2'd1,
        P_DATA = 2'd2,
        P_DONE = 2'd3
    } phase_e;
endpackage

// File: rtl/nvr_dev_match.sv
// Module: nvr_dev_match
// Decides whether an event's device address falls inside the slave's
// window of 2**LO_W consecutive addresses.
// Assumes: the window base comes from the top bits of the mapping byte,
// and bit 0 of that byte is the enable.
module nvr_dev_match #(
    parameter int DEV_W = 7,
    parameter int LO_W  = 2
) (
    input  logic [DEV_W-1:0] dev,
    input  logic [7:0]       map,
    output logic             hit
);
    localparam int HI_W = DEV_W - LO_W;

    // compare the upper device bits with the mapped base when enabled
    always_comb begin
        hit = map[0] && (dev[DEV_W-1:LO_W] == map[7:8-HI_W]);
    end
endmodule

// File: rtl/nvr_byte_store.sv
// Module: nvr_byte_store
// Byte-wide storage with one synchronous write port and one
// combinational read port.
// Assumes: the contents are not cleared by reset.
module nvr_byte_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // store one byte per write strobe
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // present the byte at the pointer
    always_comb begin
        rdata = mem[addr];
    end
endmodule

// File: rtl/nvr_xfer_ctrl.sv
// Module: nvr_xfer_ctrl
// Transfer phase machine: pointer byte, block length, then data.
// Holds the pointer, the remaining count and the dirty flag, and works
// out the answer to each event it is given.
// Assumes: at most one of start_hit, wr_hit and rd_hit is high in a cycle
// (the top ranks them).
module nvr_xfer_ctrl
    import nvr_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_hit,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic [PTR_W-9:0] dev_lo,
    input  logic [7:0]       wr_byte,
    input  logic [LEN_W-1:0] len_cfg,
    input  logic [7:0]       mem_rdata,
    input  logic             dirty_ack,
    output logic [PTR_W-1:0] ptr,
    output logic             store_en,
    output logic             ack_c,
    output logic [7:0]       byte_c,
    output logic             dirty
);
    phase_e           phase_q, phase_n;
    logic [PTR_W-1:0] ptr_q, ptr_n;
    logic [LEN_W-1:0] left_q, left_n;

    // next phase, pointer, count and answer for the event at hand
    always_comb begin
        phase_n  = phase_q;
        ptr_n    = ptr_q;
        left_n   = left_q;
        store_en = 1'b0;
        ack_c    = 1'b1;
        byte_c   = 8'h00;
        if (start_hit) begin
            phase_n = P_PTR;
        end else if (wr_hit) begin
            case (phase_q)
                P_PTR: begin
                    ptr_n   = {dev_lo, wr_byte};
                    phase_n = P_LEN;
                end
                P_LEN: begin
                    left_n = wr_byte[LEN_W-1:0];
                    if (wr_byte[LEN_W-1:0] == '0) begin
                        phase_n = P_DONE;
                        ack_c   = 1'b0;
                    end else begin
                        phase_n = P_DATA;
                    end
                end
                P_DATA: begin
                    store_en = 1'b1;
                    ptr_n    = ptr_q + 1'b1;
                    left_n   = left_q - 1'b1;
                    if (left_q <= LEN_W'(1)) begin
                        phase_n = P_DONE;
                        ack_c   = 1'b0;
                    end
                end
                default: ack_c = 1'b0;
            endcase
        end else if (rd_hit) begin
            case (phase_q)
                P_PTR, P_LEN: begin
                    byte_c[LEN_W-1:0] = len_cfg;
                    phase_n = P_DATA;
                end
                P_DATA: begin
                    byte_c = mem_rdata;
                    ptr_n  = ptr_q + 1'b1;
                end
                default: byte_c = 8'hFF;
            endcase
        end
    end

    // register the transfer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= P_PTR;
            ptr_q   <= '0;
            left_q  <= '0;
        end else begin
            phase_q <= phase_n;
            ptr_q   <= ptr_n;
            left_q  <= left_n;
        end
    end

    // dirty flag: a store sets it, the acknowledge clears it, the store wins
    always_ff @(posedge clk) begin
        if (!rst_n)         dirty <= 1'b0;
        else if (store_en)  dirty <= 1'b1;
        else if (dirty_ack) dirty <= 1'b0;
    end

    assign ptr = ptr_q;

    AST_START_TO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> phase_q == P_PTR); // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == P_DONE && !start_hit) |=> phase_q == P_DONE); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && phase_q == P_DATA) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R11
    AST_DIRTY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> $past(store_en)); // R12
endmodule

// File: rtl/smb_block_nvram.sv
// Module: smb_block_nvram (top)
// Slave for block transfers into byte memory, fed with decoded bus events.
// Answers every event it takes with a registered response one cycle later.
// Assumes: the front end raises one event per cycle; if it raises more,
// start ranks above write and write above read.
module smb_block_nvram #(
    parameter int DEV_W = 7,
    parameter int PTR_W = 10,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_wr,
    input  logic             ev_rd,
    input  logic [DEV_W-1:0] ev_dev,
    input  logic [7:0]       ev_byte,
    input  logic [7:0]       map_cfg,
    input  logic [7:0]       rd_len_cfg,
    input  logic             dirty_ack,
    output logic             rsp_valid,
    output logic             rsp_ack,
    output logic [7:0]       rsp_byte,
    output logic             dirty
);
    localparam int LO_W = PTR_W - 8;

    logic             sel;
    logic             start_hit, wr_hit, rd_hit, any_hit;
    logic [PTR_W-1:0] ptr;
    logic             store_en, ack_c;
    logic [7:0]       byte_c, mem_rdata;

    nvr_dev_match #(.DEV_W(DEV_W), .LO_W(LO_W)) u_match (
        .dev (ev_dev),
        .map (map_cfg),
        .hit (sel)
    );

    // rank simultaneous events and keep only those addressed to this slave
    always_comb begin
        start_hit = sel && ev_start;
        wr_hit    = sel && !ev_start && ev_wr;
        rd_hit    = sel && !ev_start && !ev_wr && ev_rd;
        any_hit   = start_hit || wr_hit || rd_hit;
    end

    nvr_xfer_ctrl #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_hit (start_hit),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .dev_lo    (ev_dev[LO_W-1:0]),
        .wr_byte   (ev_byte),
        .len_cfg   (rd_len_cfg[LEN_W-1:0]),
        .mem_rdata (mem_rdata),
        .dirty_ack (dirty_ack),
        .ptr       (ptr),
        .store_en  (store_en),
        .ack_c     (ack_c),
        .byte_c    (byte_c),
        .dirty     (dirty)
    );

    nvr_byte_store #(.AW(PTR_W)) u_store (
        .clk   (clk),
        .we    (store_en),
        .addr  (ptr),
        .wdata (ev_byte),
        .rdata (mem_rdata)
    );

    // register the answer to the event taken this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
            rsp_byte  <= 8'h00;
        end else begin
            rsp_valid <= any_hit;
            rsp_ack   <= any_hit && ack_c;
            rsp_byte  <= any_hit ? byte_c : 8'h00;
        end
    end

    AST_RSP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(sel && (ev_start || ev_wr || ev_rd))); // R2
    AST_IDLE_RSP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_ack && rsp_byte == 8'h00)); // R13
endmodule

// File: tb/sim_smb_block_nvram.sv
// Bench for smb_block_nvram: walks a vector table, then runs directed
// checks for reset, dirty handling and the enable bit.
module sim_smb_block_nvram;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 37;

    // vector: {req[3:0], kind[1:0] (0 start,1 write,2 read), dev[6:0],
    //          byte[7:0], exp_valid, exp_ack, exp_byte[7:0]}
    localparam logic [30:0] VEC [NVEC] = '{
        {4'd3,  2'd0, 7'h51, 8'h00, 1'b1, 1'b1, 8'h00}, // R3 start
        {4'd4,  2'd1, 7'h51, 8'h23, 1'b1, 1'b1, 8'h00}, // R4 pointer 0x123
        {4'd5,  2'd1, 7'h51, 8'h01, 1'b1, 1'b1, 8'h00}, // R5 length 1
        {4'd6,  2'd1, 7'h51, 8'h11, 1'b1, 1'b0, 8'h00}, // R6 last byte NAK
        {4'd3,  2'd0, 7'h51, 8'h00, 1'b1, 1'b1, 8'h00},
        {4'd4,  2'd1, 7'h51, 8'h20, 1'b1, 1'b1, 8'h00}, // pointer 0x120
        {4'd5,  2'd1, 7'h51, 8'hC3, 1'b1, 1'b1, 8'h00}, // R5 masked to 3
        {4'd6,  2'd1, 7'h51, 8'hA5, 1'b1, 1'b1, 8'h00},
        {4'd6,  2'd1, 7'h51, 8'h5A, 1'b1, 1'b1, 8'h00},
        {4'd6,  2'd1, 7'h51, 8'h3C, 1'b1, 1'b0, 8'h00},
        {4'd7,  2'd1, 7'h51, 8'h77, 1'b1, 1'b0, 8'h00}, // R7 refused
        {4'd10, 2'd2, 7'h51, 8'h00, 1'b1, 1'b1, 8'hFF}, // R10
        {4'd3,  2'd0, 7'h51, 8'h00, 1'b1, 1'b1, 8'h00},
        {4'd4,  2'd1, 7'h51, 8'h20, 1'b1, 1'b1, 8'h00},
        {4'd3,  2'd0, 7'h51, 8'h00, 1'b1, 1'b1, 8'h00}, // repeated start
        {4'd8,  2'd2, 7'h51, 8'h00, 1'b1, 1'b1, 8'h05}, // R8 length first
        {4'd9,  2'd2, 7'h51, 8'h00, 1'b1, 1'b1, 8'hA5}, // R9
        {4'd9,  2'd2, 7'h51, 8'h00, 1'b1, 1'b1, 8'h5A},
        {4'd9,  2'd2, 7'h51, 8'h00, 1'b1, 1'b1, 8'h3C},
        {4'd7,  2'd2, 7'h51, 8'h00, 1'b1, 1'b1, 8'h11}, // R7 0x77 not stored
        {4'd2,  2'd1, 7'h54, 8'h00, 1'b0, 1'b0, 8'h00}, // R2 outside window
        {4'd2,  2'd0, 7'h4F, 8'h00, 1'b0, 1'b0, 8'h00},
        {4'd3,  2'd0, 7'h53, 8'h00, 1'b1, 1'b1, 8'h00},
        {4'd11, 2'd1, 7'h53, 8'hFF, 1'b1, 1'b1, 8'h00}, // R11 pointer 0x3FF
        {4'd11, 2'd1, 7'h53, 8'h02, 1'b1, 1'b1, 8'h00},
        {4'd11, 2'd1, 7'h53, 8'hE1, 1'b1, 1'b1, 8'h00},
        {4'd11, 2'd1, 7'h53, 8'hE2, 1'b1, 1'b0, 8'h00},
        {4'd3,  2'd0, 7'h53, 8'h00, 1'b1, 1'b1, 8'h00},
        {4'd4,  2'd1, 7'h53, 8'hFF, 1'b1, 1'b1, 8'h00},
        {4'd8,  2'd2, 7'h53, 8'h00, 1'b1, 1'b1, 8'h05}, // R8 in length phase
        {4'd11, 2'd2, 7'h53, 8'h00, 1'b1, 1'b1, 8'hE1},
        {4'd11, 2'd2, 7'h53, 8'h00, 1'b1, 1'b1, 8'hE2}, // R11 wrapped read
        {4'd3,  2'd0, 7'h50, 8'h00, 1'b1, 1'b1, 8'h00},
        {4'd4,  2'd1, 7'h50, 8'h40, 1'b1, 1'b1, 8'h00},
        {4'd5,  2'd1, 7'h50, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 zero length
        {4'd7,  2'd1, 7'h50, 8'h99, 1'b1, 1'b0, 8'h00},
        {4'd10, 2'd2, 7'h50, 8'h00, 1'b1, 1'b1, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_wr = 1'b0, ev_rd = 1'b0;
    logic [6:0] ev_dev = '0;
    logic [7:0] ev_byte = '0;
    logic [7:0] map_cfg = 8'hA1;    // window 0x50..0x53, enabled
    logic [7:0] rd_len_cfg = 8'hC5; // length field 5
    logic       dirty_ack = 1'b0;
    logic       rsp_valid, rsp_ack, dirty;
    logic [7:0] rsp_byte;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_block_nvram u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_wr(ev_wr),
        .ev_rd(ev_rd), .ev_dev(ev_dev), .ev_byte(ev_byte),
        .map_cfg(map_cfg), .rd_len_cfg(rd_len_cfg), .dirty_ack(dirty_ack),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_byte(rsp_byte),
        .dirty(dirty)
    );

    task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // pulse one event for one cycle; the answer is on the outputs afterwards
    task automatic pulse(input logic [1:0] kind, input logic [6:0] dev, input logic [7:0] b);
        @(negedge clk);
        ev_start = (kind == 2'd0);
        ev_wr    = (kind == 2'd1);
        ev_rd    = (kind == 2'd2);
        ev_dev   = dev;
        ev_byte  = b;
        @(negedge clk);
        ev_start = 1'b0;
        ev_wr    = 1'b0;
        ev_rd    = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check(1, {rsp_valid, rsp_ack, rsp_byte}, 10'h000);
        check(1, {9'h0, dirty}, 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: the first read after reset comes from the pointer phase and returns the length
        pulse(2'd2, 7'h52, 8'h00);
        check(1, {rsp_valid, rsp_ack, rsp_byte}, {2'b11, 8'h05});
        @(negedge clk);
        // R13: the answer lasts one cycle
        check(13, {rsp_valid, rsp_ack, rsp_byte}, 10'h000);

        for (int i = 0; i < NVEC; i++) begin
            logic [30:0] v;
            v = VEC[i];
            pulse(v[26:25], v[24:18], v[17:10]);
            check(int'(v[30:27]), {rsp_valid, rsp_ack, rsp_byte}, v[9:0]);
        end

        // R12: the table stored bytes, so dirty is set; the acknowledge clears it
        check(12, {9'h0, dirty}, 10'h001);
        @(negedge clk) dirty_ack = 1'b1;
        @(negedge clk) dirty_ack = 1'b0;
        check(12, {9'h0, dirty}, 10'h000);

        // R12: a store in the same cycle as the acknowledge leaves dirty set
        pulse(2'd0, 7'h52, 8'h00);
        pulse(2'd1, 7'h52, 8'h10);
        pulse(2'd1, 7'h52, 8'h02);
        @(negedge clk);
        ev_wr = 1'b1; ev_byte = 8'h44; dirty_ack = 1'b1;
        @(negedge clk);
        ev_wr = 1'b0; dirty_ack = 1'b0;
        check(12, {9'h0, dirty}, 10'h001);
        check(6, {rsp_valid, rsp_ack, rsp_byte}, {2'b11, 8'h00});

        // R2: with the enable bit clear, a start gets no answer and the transfer stays in the data phase
        map_cfg = 8'hA0;
        pulse(2'd0, 7'h52, 8'h00);
        check(2, {rsp_valid, rsp_ack, rsp_byte}, 10'h000);
        map_cfg = 8'hA1;
        pulse(2'd1, 7'h52, 8'h55); // last byte of the open transfer
        check(2, {rsp_valid, rsp_ack, rsp_byte}, {2'b10, 8'h00});

        // R1: a new reset clears dirty and the transfer phase
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check(1, {9'h0, dirty}, 10'h000);
        pulse(2'd1, 7'h52, 8'h10); // pointer phase: ACK
        check(1, {rsp_valid, rsp_ack, rsp_byte}, {2'b11, 8'h00});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule